// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external host read and write a small bank of 8-bit control registers through a four-wire serial port: an active-low chip select, a serial clock, a serial data input and a serial data output with its own output enable. The serial pins are sampled by a faster system clock. The register contents are presented continuously as a flat parallel bus for the logic they configure.

Every frame holds sixteen bits and starts when chip select falls. The first bit gives the direction. It is followed by a 7-bit register index and then an 8-bit data byte, and every field is sent most significant bit first. A write stores the data byte in the indexed register. A read returns that register on the serial output during the data byte, and the output enable is low at all other times. Releasing chip select at any point ends the frame.

Top module: `cfg_spi_regbank`

## Requirements
- R1: After reset all five registers read 0x00 on `cfg_q`, and `spi_sdo_oe` is low.
- R2: The direction bit is the first bit after chip select falls, and a value of 0 selects a write. In a write frame, the seven index bits (most significant first) and then eight data bits (most significant first) store the data byte in register `index`. Register `k` occupies `cfg_q[8k+7:8k]`.
- R3: The direction bit value 1 selects a read. In a read frame, `spi_sdo` presents the indexed register's bit 7 through bit 0, one bit per data-phase SCK rising edge, changing after SCK falling edges so that each bit is stable at the rising edge.
- R4: `spi_sdo_oe` stays low during the direction and index phases of every frame and throughout a write frame.
- R5: `spi_sdo_oe` is high across the eight data-phase rising edges of a read frame and returns low after chip select rises.
- R6: A write to an index of 5 or more changes no register.
- R7: A read from an index of 5 or more returns 0x00.
- R8: Raising chip select before the sixteenth rising edge abandons the frame: a partial write stores nothing, and the next frame is decoded from its first bit.
- R9: With SCK rising on a falling system-clock edge, a write's register change appears on `cfg_q` at the fourth rising system-clock edge after the sixteenth SCK rise, and `cfg_q` holds its value in every other cycle.
- R10: SCK rising edges after the sixteenth within one chip-select window have no effect on registers or on the bit count.
- R11: SDI values during the data phase of a read do not alter any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Active-low chip select; high aborts any frame |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from host, sampled on SCK rise |
| spi_sdo | output | 1 | Serial read data to host |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad driver; low means high impedance |
| cfg_q | output | 40 | Register contents, register k in bits 8k+7..8k |

## Verification
The case that is hardest to reach from the pins is a frame that ends before its sixteenth edge and is followed at once by a clean frame. Here a stale bit count or a stale direction would corrupt the next frame without any visible error. The stimulus cuts a write after twelve bits and a read after eleven bits, partway through its data phase, and then runs a full write and a full read-back of the same register. A per-cycle register model also confirms that the aborted write never reaches `cfg_q`. Frames carrying extra SCK edges after the sixteenth, and reads that drive all-ones on SDI during the data phase, cover the other inputs that must have no effect.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  localparam int IDX_W      = 7;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 1 + IDX_W + BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int HOLD_W     = FRAME_BITS - 2;
  localparam int IDX_DONE   = 1 + IDX_W;

  typedef struct packed {
    logic              we;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] data;
  } cfg_wr_t;

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [31:0] IDLE    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= IDLE[b];
        sync_q[b] <= IDLE[b];
      end else begin
        meta_q[b] <= d_async[b];
        sync_q[b] <= meta_q[b];
      end
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_spi_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_s,
  input  logic                    sck_s,
  input  logic                    sdi_s,
  input  logic [BYTE_W-1:0]       rd_data,
  output logic [IDX_W-1:0]        rd_idx,
  output cfg_wr_t                 wr_req,
  output logic [CNT_W-1:0]        bit_cnt,
  output logic                    sdo,
  output logic                    sdo_oe
);

  logic               sck_prev_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               dir_q, dir_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;
  logic [BYTE_W-1:0]  out_q, out_d;
  logic               oe_q, oe_d;
  cfg_wr_t            wr_q, wr_d;
  logic               sck_rise, sck_fall;
  logic               in_data_out;

  assign sck_rise    = sck_s & ~sck_prev_q & ~cs_s;
  assign sck_fall    = ~sck_s & sck_prev_q & ~cs_s;
  assign in_data_out = (cnt_q > CNT_W'(IDX_DONE)) && (cnt_q < CNT_W'(FRAME_BITS));

  always_comb begin
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    hold_d  = hold_q;
    out_d   = out_q;
    oe_d    = oe_q;
    wr_d    = '0;
    if (cs_s) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      if (sck_rise && (cnt_q < CNT_W'(FRAME_BITS))) begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == '0) begin
          dir_d = sdi_s;
        end else begin
          hold_d = {hold_q[HOLD_W-2:0], sdi_s};
        end
        if ((cnt_q == CNT_W'(FRAME_BITS - 1)) && !dir_q) begin
          wr_d.we   = 1'b1;
          wr_d.idx  = hold_q[HOLD_W-1 -: IDX_W];
          wr_d.data = {hold_q[BYTE_W-2:0], sdi_s};
        end
      end
      if (sck_fall) begin
        if ((cnt_q == CNT_W'(IDX_DONE)) && dir_q) begin
          out_d = rd_data;
          oe_d  = 1'b1;
        end else if (in_data_out && oe_q) begin
          out_d = {out_q[BYTE_W-2:0], 1'b0};
        end else if (cnt_q == CNT_W'(FRAME_BITS)) begin
          oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      hold_q     <= '0;
      out_q      <= '0;
      oe_q       <= 1'b0;
      wr_q       <= '0;
    end else begin
      sck_prev_q <= sck_s;
      cnt_q      <= cnt_d;
      dir_q      <= dir_d;
      hold_q     <= hold_d;
      out_q      <= out_d;
      oe_q       <= oe_d;
      wr_q       <= wr_d;
    end
  end

  assign rd_idx  = hold_q[IDX_W-1:0];
  assign wr_req  = wr_q;
  assign bit_cnt = cnt_q;
  assign sdo     = out_q[BYTE_W-1];
  assign sdo_oe  = oe_q;

endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cfg_wr_t                    wr_req,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);

  logic [BYTE_W-1:0] reg_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_req.we && (wr_req.idx == IDX_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[r] <= '0;
      end else if (hit) begin
        reg_q[r] <= wr_req.data;
      end
    end
    assign regs_flat[r*BYTE_W +: BYTE_W] = reg_q[r];
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_idx == IDX_W'(r)) begin
        rd_data = reg_q[r];
      end
    end
  end

endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_cs_n,
  input  logic                       spi_sck,
  input  logic                       spi_sdi,
  output logic                       spi_sdo,
  output logic                       spi_sdo_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_q
);

  logic              rst_meta_q;
  logic              rst_core_n;
  logic [2:0]        pins_s;
  logic              cs_s;
  logic              sck_s;
  logic              sdi_s;
  logic [IDX_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] rd_data;
  logic [CNT_W-1:0]  bit_cnt;
  cfg_wr_t           wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  cfg_spi_sync #(
    .WIDTH (3),
    .IDLE  (32'h4)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .d_async ({spi_cs_n, spi_sck, spi_sdi}),
    .q_sync  (pins_s)
  );

  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  cfg_spi_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cs_s    (cs_s),
    .sck_s   (sck_s),
    .sdi_s   (sdi_s),
    .rd_data (rd_data),
    .rd_idx  (rd_idx),
    .wr_req  (wr_req),
    .bit_cnt (bit_cnt),
    .sdo     (spi_sdo),
    .sdo_oe  (spi_sdo_oe)
  );

  cfg_spi_bank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_req    (wr_req),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .regs_flat (cfg_q)
  );

endmodule

// File: rtl/cfg_spi_regbank_chk.sv
module cfg_spi_regbank_chk
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_s,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic                       sdo_oe,
  input cfg_wr_t                    wr_req,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_q
);

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= FRAME_BITS);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0) && !sdo_oe);

  assert_oe_data_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> int'(bit_cnt) >= IDX_DONE);

  assert_wr_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req.we |-> int'(bit_cnt) == FRAME_BITS);

  assert_unmapped_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req.we && int'(wr_req.idx) >= NUM_REGS) |=> $stable(cfg_q));

  assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req.we |=> $stable(cfg_q));

endmodule

bind cfg_spi_regbank cfg_spi_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .cs_s    (cs_s),
  .bit_cnt (bit_cnt),
  .sdo_oe  (spi_sdo_oe),
  .wr_req  (wr_req),
  .cfg_q   (cfg_q)
);

// File: tb/cfg_spi_regbank_bench.sv
module cfg_spi_regbank_bench;

  localparam int NREG = 5;
  localparam int HALF = 4;

  logic            clk;
  logic            rst_n;
  logic            cs_n;
  logic            sck;
  logic            sdi;
  logic            sdo;
  logic            sdo_oe;
  logic [NREG*8-1:0] cfg_q;

  logic [NREG*8-1:0] exp_q;
  int vectors;
  int miscompares;
  bit running;
  bit done;

  cfg_spi_regbank #(.NUM_REGS(NREG)) u_cfg_spi_regbank (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (cs_n),
    .spi_sck    (sck),
    .spi_sdi    (sdi),
    .spi_sdo    (sdo),
    .spi_sdo_oe (sdo_oe),
    .cfg_q      (cfg_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  // Per-cycle register model comparison (R9 timing, R2/R6/R8/R10/R11 effects)
  always @(negedge clk) begin
    if (running) begin
      check(cfg_q === exp_q, "R9 cfg_q per-cycle", int'(cfg_q[31:0]), int'(exp_q[31:0]));
    end
  end

  function automatic logic [7:0] model_rd(input int idx);
    return (idx < NREG) ? exp_q[idx*8 +: 8] : 8'h00;
  endfunction

  // One frame: dir 1=read, 0=write; nbits rises before cs release; extra rises after 16
  task automatic frame(input bit dir, input logic [6:0] idx, input logic [7:0] dat,
                       input int nbits, input int extra);
    logic [15:0] bits;
    logic [7:0]  rexp;
    bits = {dir, idx, dat};
    rexp = model_rd(int'(idx));
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[15-i];
      repeat (HALF) @(negedge clk);
      if (i < 8 || !dir) begin
        check(sdo_oe === 1'b0, "R4 oe low outside read data", int'(sdo_oe), 0);
      end else begin
        check(sdo_oe === 1'b1, "R5 oe high in read data", int'(sdo_oe), 1);
        if (idx < NREG)
          check(sdo === rexp[15-i], "R3 sdo bit", int'(sdo), int'(rexp[15-i]));
        else
          check(sdo === 1'b0, "R7 unmapped read bit", int'(sdo), 0);
      end
      sck = 1'b1;
      if (i == 15 && !dir) begin
        repeat (4) @(posedge clk);
        if (idx < NREG) exp_q[int'(idx)*8 +: 8] = dat;
        @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sck = 1'b0;
    end
    for (int e = 0; e < extra; e++) begin
      sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (8) @(negedge clk);
    check(sdo_oe === 1'b0, "R5 oe low after cs high", int'(sdo_oe), 0);
  endtask

  initial begin
    vectors = 0; miscompares = 0; running = 1'b0; done = 1'b0;
    cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; exp_q = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_q === '0, "R1 regs zero", int'(cfg_q[31:0]), 0);
    check(sdo_oe === 1'b0, "R1 oe low", int'(sdo_oe), 0);
    running = 1'b1;

    // R2 writes with distinct patterns
    frame(1'b0, 7'd0, 8'hA5, 16, 0);
    frame(1'b0, 7'd1, 8'h3C, 16, 0);
    frame(1'b0, 7'd2, 8'hFF, 16, 0);
    frame(1'b0, 7'd3, 8'h01, 16, 0);
    frame(1'b0, 7'd4, 8'h80, 16, 0);
    // R3 read-back of every register
    for (int r = 0; r < NREG; r++) frame(1'b1, 7'(r), 8'h00, 16, 0);
    // R6 unmapped writes, R7 unmapped reads
    frame(1'b0, 7'd5,  8'h55, 16, 0);
    frame(1'b0, 7'h7F, 8'hAA, 16, 0);
    frame(1'b1, 7'd5,  8'h00, 16, 0);
    frame(1'b1, 7'h7F, 8'h00, 16, 0);
    frame(1'b1, 7'h40, 8'h00, 16, 0);
    // R11 SDI ones during read data phase
    frame(1'b1, 7'd3, 8'hFF, 16, 0);
    frame(1'b1, 7'd3, 8'h00, 16, 0);
    // R8 aborted write then clean frames
    frame(1'b0, 7'd1, 8'h99, 12, 0);
    frame(1'b1, 7'd1, 8'h00, 16, 0);
    frame(1'b1, 7'd0, 8'h00, 11, 0);
    frame(1'b0, 7'd1, 8'h5A, 16, 0);
    frame(1'b1, 7'd1, 8'h00, 16, 0);
    // R10 extra SCK rises after the frame
    frame(1'b0, 7'd2, 8'h12, 16, 3);
    frame(1'b1, 7'd2, 8'h00, 16, 2);
    frame(1'b1, 7'd4, 8'h00, 16, 0);

    running = 1'b0;
    check(cfg_q === exp_q, "R2 final registers", int'(cfg_q[31:0]), int'(exp_q[31:0]));
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule